// File: doc/BRIEF.md
# Page-Table Entry Accessed/Dirty Bit Updater

This block runs once a page-table walk has produced a leaf entry. It decides whether the entry's accessed flag (bit 6) or dirty flag (bit 7) must be raised for the pending access. Any access (load, store or instruction fetch) needs the accessed flag. A store also needs the dirty flag. When nothing is missing, the block finishes at once without touching memory. When a flag is missing, a static mode pin selects the response. In hardware-update mode the block performs a locked read-check-write of the entry in memory. In trap mode it reports an access fault and leaves the entry as it is.

A hardware update waits for a commit strobe, so a speculative access never causes a memory write. While the read, the re-check and the write-back are in progress, the block holds a lock line on its memory port. It re-reads the entry under that lock and checks again that the entry is valid and still grants the access. If the check fails, it faults and writes nothing. The value written back is the re-read entry with the missing flags ORed in, so no flag is ever cleared. Every request ends in exactly one single-cycle pulse, either done or fault. On done the final entry is presented. On fault the access kind is presented so the caller can choose the fault cause.

The entry uses this bit layout: valid bit 0, read bit 1, write bit 2, execute bit 3, user bit 4, global bit 5, accessed bit 6, dirty bit 7. Access kind is coded 0 = load, 1 = store, 2 = fetch.

Top module: `pte_ad_updater`

## Requirements
- R1: In hardware-update mode, an access of any kind to a valid, permitted entry whose accessed flag (bit 6) is clear ends with the entry in memory and on `finalPte` having bit 6 set, after one locked read and one write.
- R2: A store whose entry has the dirty flag (bit 7) clear sets bit 7 as well. A store with both flags clear sets both in a single write.
- R3: In trap mode (`hwUpdate` = 0), a request that needs a flag raised ends in a fault pulse with no memory access, and the entry is unchanged.
- R4: When the needed flags are already set, the request ends in a done pulse with no memory access, in either mode.
- R5: No memory access is made for a request until `reqCommit` is high. The block waits indefinitely while it is low.
- R6: `memLock` is high during every memory request, and stays high without a gap from the read request through the write acknowledge.
- R7: After the locked re-read, if the entry is not valid or lacks the needed permission (read bit 1 for a load, write bit 2 for a store, execute bit 3 for a fetch), the block faults and issues no write.
- R8: The written value is the re-read value with flags only added. No bit that was set is ever cleared.
- R9: Each accepted request produces exactly one of `doneValid` or `faultValid`. Each is a one-cycle pulse, and the two are never high together.
- R10: A request whose `reqPermOk` is low, or whose entry has the valid bit clear, faults immediately with no memory access.
- R11: During a fault pulse, `faultKind` carries the request's access kind (0 load, 1 store, 2 fetch). During a done pulse, `finalPte` carries the entry as it now stands in memory.
- R12: If the re-read entry already holds the needed flags (set meanwhile by another agent), the block completes with done and no write, and `finalPte` shows the re-read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a request (accepted when idle) |
| reqPte | input | PTE_W | Leaf entry found by the walk |
| reqAddr | input | PADDR_W | Physical address of the entry |
| reqKind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| reqPermOk | input | 1 | Upstream permission check passed |
| reqCommit | input | 1 | Access is committed (non-speculative) |
| hwUpdate | input | 1 | 1 = hardware update, 0 = trap on missing flag |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memLock | output | 1 | Hold the bus for this requester only |
| memAddr | output | PADDR_W | Entry address |
| memWdata | output | PTE_W | Write data |
| memRdata | input | PTE_W | Read data, valid with memAck |
| memAck | input | 1 | Request completes this cycle |
| doneValid | output | 1 | One-cycle success pulse |
| faultValid | output | 1 | One-cycle access-fault pulse |
| faultKind | output | 2 | Access kind of the faulting request |
| finalPte | output | PTE_W | Resulting entry |

## Verification
A table drives loads, stores and fetches against entries with neither flag, only accessed, or both flags set, in both modes. This separates the write path from the immediate-done and trap paths, and shows whether the dirty flag is tied to stores only. Rows with the upstream permission low, the valid bit clear, or a missing write or execute permission show whether the early check and the locked re-check each take effect, counted by memory accesses. Directed runs hold the commit strobe low to expose premature bus traffic. They also change the entry in memory between request and commit, setting the flags in one run and clearing the valid bit in another, which shows that the decision comes from the locked re-read and not from the stale input.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;
  localparam int FLAG_W = 8;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_STORE = 2'd1,
    KIND_FETCH = 2'd2
  } accKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_COMMIT,
    ST_LOCK_READ,
    ST_CHECK,
    ST_WRITE,
    ST_DONE,
    ST_FAULT
  } updState_e;

  typedef struct packed {
    logic latchReq;
    logic captureRead;
    logic commitWrite;
  } ctlStrobes_t;

  // Flags that the access needs and the entry lacks.
  function automatic logic [FLAG_W-1:0] missingFlags(input logic [FLAG_W-1:0] flags,
                                                     input accKind_e kind);
    logic [FLAG_W-1:0] m;
    m = '0;
    m[BIT_A] = ~flags[BIT_A];
    m[BIT_D] = (kind == KIND_STORE) && ~flags[BIT_D];
    return m;
  endfunction

  // Valid and the permission bit matching the access kind.
  function automatic logic grantsAccess(input logic [FLAG_W-1:0] flags,
                                        input accKind_e kind);
    logic permBit;
    case (kind)
      KIND_LOAD:  permBit = flags[BIT_R];
      KIND_STORE: permBit = flags[BIT_W];
      KIND_FETCH: permBit = flags[BIT_X];
      default:    permBit = 1'b0;
    endcase
    return flags[BIT_V] && permBit;
  endfunction

endpackage

// File: rtl/pte_ad_datapath.sv
module pte_ad_datapath
  import pte_ad_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int PADDR_W = 34
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PTE_W-1:0]   reqPte,
  input  logic [PADDR_W-1:0] reqAddr,
  input  logic [1:0]         reqKind,
  input  logic               reqPermOk,
  input  logic [PTE_W-1:0]   memRdata,
  input  ctlStrobes_t        strb,
  output logic               reqEntryOk,
  output logic               reqNeedsUpdate,
  output logic               freshOk,
  output logic               freshNeedsUpdate,
  output logic [PADDR_W-1:0] memAddr,
  output logic [PTE_W-1:0]   memWdata,
  output logic [PTE_W-1:0]   finalPte,
  output logic [1:0]         faultKind
);

  localparam int HI_W = PTE_W - FLAG_W;

  logic [PTE_W-1:0]   pteQ;
  logic [PADDR_W-1:0] addrQ;
  accKind_e           kindQ;
  accKind_e           reqKindE;
  logic [FLAG_W-1:0]  needFresh;
  logic [PTE_W-1:0]   setMask;

  assign reqKindE = accKind_e'(reqKind);

  // Early decision on the entry handed over by the walk.
  assign reqEntryOk     = reqPermOk && reqPte[BIT_V];
  assign reqNeedsUpdate = |missingFlags(reqPte[FLAG_W-1:0], reqKindE);

  // Decision on the locked re-read.
  assign needFresh        = missingFlags(pteQ[FLAG_W-1:0], kindQ);
  assign freshOk          = grantsAccess(pteQ[FLAG_W-1:0], kindQ);
  assign freshNeedsUpdate = |needFresh;

  generate
    if (HI_W > 0) begin : g_wide
      assign setMask = {{HI_W{1'b0}}, needFresh};
    end else begin : g_narrow
      assign setMask = needFresh;
    end
  endgenerate

  assign memWdata  = pteQ | setMask;
  assign memAddr   = addrQ;
  assign finalPte  = pteQ;
  assign faultKind = kindQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pteQ  <= '0;
      addrQ <= '0;
      kindQ <= KIND_LOAD;
    end else begin
      if (strb.latchReq) begin
        pteQ  <= reqPte;
        addrQ <= reqAddr;
        kindQ <= reqKindE;
      end else if (strb.captureRead) begin
        pteQ <= memRdata;
      end else if (strb.commitWrite) begin
        pteQ <= memWdata;
      end
    end
  end

  // R8: a write-back only adds bits to the held entry
  p_write_only_adds_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> (($past(pteQ) & ~pteQ) == '0));

  // R1: after a write-back the accessed flag is set
  p_write_sets_accessed_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> pteQ[BIT_A]);

  // R2: a store write-back also leaves the dirty flag set
  p_store_sets_dirty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWrite && kindQ == KIND_STORE) |=> pteQ[BIT_D]);

endmodule

// File: rtl/pte_ad_ctrl.sv
module pte_ad_ctrl
  import pte_ad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqCommit,
  input  logic        hwUpdate,
  input  logic        memAck,
  input  logic        reqEntryOk,
  input  logic        reqNeedsUpdate,
  input  logic        freshOk,
  input  logic        freshNeedsUpdate,
  output ctlStrobes_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        memLock,
  output logic        doneValid,
  output logic        faultValid
);

  updState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.latchReq = 1'b1;
          if (!reqEntryOk)          stateD = ST_FAULT;
          else if (!reqNeedsUpdate) stateD = ST_DONE;
          else if (!hwUpdate)       stateD = ST_FAULT;
          else                      stateD = ST_WAIT_COMMIT;
        end
      end
      ST_WAIT_COMMIT: begin
        if (reqCommit) stateD = ST_LOCK_READ;
      end
      ST_LOCK_READ: begin
        if (memAck) begin
          strb.captureRead = 1'b1;
          stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!freshOk)               stateD = ST_FAULT;
        else if (!freshNeedsUpdate) stateD = ST_DONE;
        else                        stateD = ST_WRITE;
      end
      ST_WRITE: begin
        if (memAck) begin
          strb.commitWrite = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE:  stateD = ST_IDLE;
      ST_FAULT: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq     = (stateQ == ST_LOCK_READ) || (stateQ == ST_WRITE);
  assign memWe      = (stateQ == ST_WRITE);
  assign memLock    = (stateQ == ST_LOCK_READ) || (stateQ == ST_CHECK) || (stateQ == ST_WRITE);
  assign doneValid  = (stateQ == ST_DONE);
  assign faultValid = (stateQ == ST_FAULT);

  // R9: never both outcomes together, each a single-cycle pulse
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_fault_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> !faultValid);

  // R5: the locked read starts only after a committed cycle
  p_commit_before_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReq) && !memWe) |-> $past(reqCommit));

  // R6: every request is under lock, and the lock is dropped only on an outcome
  p_req_under_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memLock);
  p_lock_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memLock) |-> (doneValid || faultValid));

endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
  import pte_ad_pkg::*;
#(
  parameter int PTE_W   = 32,
  parameter int PADDR_W = 34
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [PTE_W-1:0]   reqPte,
  input  logic [PADDR_W-1:0] reqAddr,
  input  logic [1:0]         reqKind,
  input  logic               reqPermOk,
  input  logic               reqCommit,
  input  logic               hwUpdate,
  output logic               memReq,
  output logic               memWe,
  output logic               memLock,
  output logic [PADDR_W-1:0] memAddr,
  output logic [PTE_W-1:0]   memWdata,
  input  logic [PTE_W-1:0]   memRdata,
  input  logic               memAck,
  output logic               doneValid,
  output logic               faultValid,
  output logic [1:0]         faultKind,
  output logic [PTE_W-1:0]   finalPte
);

  ctlStrobes_t strb;
  logic        reqEntryOk;
  logic        reqNeedsUpdate;
  logic        freshOk;
  logic        freshNeedsUpdate;

  pte_ad_ctrl i_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .reqValid         (reqValid),
    .reqCommit        (reqCommit),
    .hwUpdate         (hwUpdate),
    .memAck           (memAck),
    .reqEntryOk       (reqEntryOk),
    .reqNeedsUpdate   (reqNeedsUpdate),
    .freshOk          (freshOk),
    .freshNeedsUpdate (freshNeedsUpdate),
    .strb             (strb),
    .memReq           (memReq),
    .memWe            (memWe),
    .memLock          (memLock),
    .doneValid        (doneValid),
    .faultValid       (faultValid)
  );

  pte_ad_datapath #(
    .PTE_W   (PTE_W),
    .PADDR_W (PADDR_W)
  ) i_datapath (
    .clk              (clk),
    .rstN             (rstN),
    .reqPte           (reqPte),
    .reqAddr          (reqAddr),
    .reqKind          (reqKind),
    .reqPermOk        (reqPermOk),
    .memRdata         (memRdata),
    .strb             (strb),
    .reqEntryOk       (reqEntryOk),
    .reqNeedsUpdate   (reqNeedsUpdate),
    .freshOk          (freshOk),
    .freshNeedsUpdate (freshNeedsUpdate),
    .memAddr          (memAddr),
    .memWdata         (memWdata),
    .finalPte         (finalPte),
    .faultKind        (faultKind)
  );

endmodule

// File: tb/test_pte_ad_updater.sv
module test_pte_ad_updater;

  localparam int PTE_W   = 32;
  localparam int PADDR_W = 34;
  localparam logic [31:0] BASE = 32'h2468_A000;

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] kind;
    logic [7:0] flags;
    logic       hw;
    logic       permOk;
    logic       expFault;
    logic [7:0] expFlags;
    logic [1:0] expAcc;
  } vec_t;

  // Flags: V=01 R=02 W=04 X=08 A=40 D=80; kind 0 load, 1 store, 2 fetch
  localparam vec_t VECS [14] = '{
    '{4'd1,  2'd0, 8'h0F, 1'b1, 1'b1, 1'b0, 8'h4F, 2'd2},  // R1 load sets A
    '{4'd2,  2'd1, 8'h0F, 1'b1, 1'b1, 1'b0, 8'hCF, 2'd2},  // R2 store sets A and D
    '{4'd1,  2'd2, 8'h09, 1'b1, 1'b1, 1'b0, 8'h49, 2'd2},  // R1 fetch sets A
    '{4'd2,  2'd1, 8'h4F, 1'b1, 1'b1, 1'b0, 8'hCF, 2'd2},  // R2 store sets D only
    '{4'd4,  2'd0, 8'h4F, 1'b1, 1'b1, 1'b0, 8'h4F, 2'd0},  // R4 hw mode, nothing missing
    '{4'd4,  2'd1, 8'hCF, 1'b0, 1'b1, 1'b0, 8'hCF, 2'd0},  // R4 trap mode, nothing missing
    '{4'd3,  2'd0, 8'h0F, 1'b0, 1'b1, 1'b1, 8'h0F, 2'd0},  // R3 load trap
    '{4'd3,  2'd1, 8'h4F, 1'b0, 1'b1, 1'b1, 8'h4F, 2'd0},  // R3 store trap on D
    '{4'd3,  2'd2, 8'h09, 1'b0, 1'b1, 1'b1, 8'h09, 2'd0},  // R3 fetch trap
    '{4'd10, 2'd0, 8'h0F, 1'b1, 1'b0, 1'b1, 8'h0F, 2'd0},  // R10 upstream permission low
    '{4'd7,  2'd1, 8'h0B, 1'b1, 1'b1, 1'b1, 8'h0B, 2'd1},  // R7 no write permission
    '{4'd7,  2'd2, 8'h07, 1'b1, 1'b1, 1'b1, 8'h07, 2'd1},  // R7 no execute permission
    '{4'd10, 2'd0, 8'h0E, 1'b1, 1'b1, 1'b1, 8'h0E, 2'd0},  // R10 valid clear
    '{4'd4,  2'd2, 8'h49, 1'b0, 1'b1, 1'b0, 8'h49, 2'd0}   // R4 fetch, trap mode
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic [PTE_W-1:0]   reqPte = '0;
  logic [PADDR_W-1:0] reqAddr = '0;
  logic [1:0]         reqKind = '0;
  logic               reqPermOk = 1'b0;
  logic               reqCommit = 1'b0;
  logic               hwUpdate = 1'b0;
  logic               memReq, memWe, memLock, memAck;
  logic [PADDR_W-1:0] memAddr;
  logic [PTE_W-1:0]   memWdata, memRdata;
  logic               doneValid, faultValid;
  logic [1:0]         faultKind;
  logic [PTE_W-1:0]   finalPte;

  logic [31:0] mem [16];
  logic        hostWrEn = 1'b0;
  logic [3:0]  hostWrIdx = '0;
  logic [31:0] hostWrData = '0;

  int checks = 0;
  int fails = 0;
  int accCount = 0, wrCount = 0, doneCount = 0, faultCount = 0;
  int lockViol = 0, clearViol = 0;
  logic inRmw = 1'b0;

  always #4 clk = ~clk;

  pte_ad_updater #(.PTE_W(PTE_W), .PADDR_W(PADDR_W)) i_pte_ad_updater (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPte(reqPte), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqPermOk(reqPermOk), .reqCommit(reqCommit), .hwUpdate(hwUpdate),
    .memReq(memReq), .memWe(memWe), .memLock(memLock), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .doneValid(doneValid), .faultValid(faultValid), .faultKind(faultKind), .finalPte(finalPte)
  );

  assign memAck   = memReq;
  assign memRdata = mem[memAddr[5:2]];

  always @(posedge clk) begin
    if (hostWrEn) mem[hostWrIdx] <= hostWrData;
    else if (memReq && memAck && memWe) mem[memAddr[5:2]] <= memWdata;
  end

  // Bus monitor
  always @(posedge clk) begin
    if (rstN) begin
      if (memReq && memAck) accCount <= accCount + 1;
      if (memReq && memAck && memWe) begin
        wrCount <= wrCount + 1;
        if ((mem[memAddr[5:2]] & ~memWdata) != 0) clearViol <= clearViol + 1;
      end
      if (memReq && !memLock) lockViol <= lockViol + 1;
      if (inRmw && !memLock && !(doneValid || faultValid)) lockViol <= lockViol + 1;
      if (memReq && memAck && !memWe) inRmw <= 1'b1;
      else if (doneValid || faultValid) inRmw <= 1'b0;
      if (doneValid) doneCount <= doneCount + 1;
      if (faultValid) faultCount <= faultCount + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pokeMem(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrIdx = idx; hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [31:0] pte, input logic [3:0] idx,
                       input logic permOk);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqPte = pte; reqPermOk = permOk;
    reqAddr = {{(PADDR_W-6){1'b0}}, idx, 2'b00};
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitOutcome(output logic gotDone, output logic gotFault,
                             output logic [31:0] pteOut, output logic [1:0] kindOut);
    gotDone = 1'b0; gotFault = 1'b0; pteOut = '0; kindOut = '0;
    for (int i = 0; i < 100; i++) begin
      if (doneValid || faultValid) begin
        gotDone = doneValid; gotFault = faultValid;
        pteOut = finalPte; kindOut = faultKind;
        break;
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic gd, gf;
    logic [31:0] pOut;
    logic [1:0] kOut;
    int acc0, wr0, out0;
    for (int i = 0; i < 16; i++) mem[i] = BASE;

    repeat (3) @(negedge clk);
    // R9 reset state: no outcome, no bus activity
    chk(!doneValid && !faultValid, "R9 reset outcome idle", {doneValid, faultValid}, 0);
    chk(!memReq && !memLock, "R6 reset bus idle", {memReq, memLock}, 0);
    rstN = 1'b1;
    reqCommit = 1'b1;

    foreach (VECS[r]) begin
      vec_t v;
      logic [3:0] idx;
      v = VECS[r];
      idx = 4'(r);
      pokeMem(idx, BASE | {24'h0, v.flags});
      hwUpdate = v.hw;
      acc0 = accCount; out0 = doneCount + faultCount;
      issue(v.kind, BASE | {24'h0, v.flags}, idx, v.permOk);
      waitOutcome(gd, gf, pOut, kOut);
      chk(gf == v.expFault && gd == !v.expFault, $sformatf("R%0d row %0d outcome", v.req, r),
          {gd, gf}, {!v.expFault, v.expFault});
      chk(doneCount + faultCount - out0 == 1, $sformatf("R9 row %0d single pulse", r),
          doneCount + faultCount - out0, 1);
      chk(mem[idx] == (BASE | {24'h0, v.expFlags}), $sformatf("R%0d row %0d memory", v.req, r),
          mem[idx], BASE | {24'h0, v.expFlags});
      chk(pOut == (BASE | {24'h0, v.expFlags}), $sformatf("R11 row %0d finalPte", r),
          pOut, BASE | {24'h0, v.expFlags});
      chk(accCount - acc0 == int'(v.expAcc), $sformatf("R%0d row %0d access count", v.req, r),
          accCount - acc0, v.expAcc);
      if (v.expFault)
        chk(kOut == v.kind, $sformatf("R11 row %0d faultKind", r), kOut, v.kind);
    end

    // R5: speculative request waits without touching memory
    hwUpdate = 1'b1;
    reqCommit = 1'b0;
    pokeMem(4'd14, BASE | 32'h0F);
    acc0 = accCount; out0 = doneCount + faultCount;
    issue(2'd0, BASE | 32'h0F, 4'd14, 1'b1);
    repeat (20) @(negedge clk);
    chk(accCount == acc0, "R5 no access before commit", accCount - acc0, 0);
    chk(doneCount + faultCount == out0, "R5 no outcome before commit", doneCount + faultCount - out0, 0);
    reqCommit = 1'b1;
    waitOutcome(gd, gf, pOut, kOut);
    chk(gd && mem[14] == (BASE | 32'h4F), "R5 completes after commit", mem[14], BASE | 32'h4F);

    // R12: another agent sets the flag before commit
    reqCommit = 1'b0;
    pokeMem(4'd15, BASE | 32'h0F);
    acc0 = accCount; wr0 = wrCount;
    issue(2'd0, BASE | 32'h0F, 4'd15, 1'b1);
    pokeMem(4'd15, BASE | 32'h4F);
    reqCommit = 1'b1;
    waitOutcome(gd, gf, pOut, kOut);
    chk(gd && !gf, "R12 done on fresh flags", {gd, gf}, 2'b10);
    chk(wrCount == wr0 && accCount - acc0 == 1, "R12 read but no write", wrCount - wr0, 0);
    chk(pOut == (BASE | 32'h4F), "R12 finalPte is re-read value", pOut, BASE | 32'h4F);

    // R7: another agent clears valid before commit
    reqCommit = 1'b0;
    pokeMem(4'd13, BASE | 32'h0F);
    wr0 = wrCount;
    issue(2'd1, BASE | 32'h0F, 4'd13, 1'b1);
    pokeMem(4'd13, BASE | 32'h0E);
    reqCommit = 1'b1;
    waitOutcome(gd, gf, pOut, kOut);
    chk(gf && kOut == 2'd1, "R7 fault on invalid re-read", {gf, kOut}, 3'b101);
    chk(wrCount == wr0 && mem[13] == (BASE | 32'h0E), "R7 no write after failed re-check",
        mem[13], BASE | 32'h0E);

    chk(lockViol == 0, "R6 lock held across read-check-write", lockViol, 0);
    chk(clearViol == 0, "R8 no flag ever cleared", clearViol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule